// File: doc/BRIEF.md
# Two-Phase Full-Frame CCD Quadrant Clock Sequencer

This block produces the logic-level clock phases that read one quadrant of a two-phase full-frame CCD. A start pulse begins a frame. The vertical phases are then held low for a programmable integration time. After that the block transfers each line into the horizontal register with a three-step vertical pulse. It holds the horizontal register for a short setup window and then shifts every pixel of the line toward the sense node using complementary horizontal phases. When the last line has been shifted out, the block returns to idle.

The reset-gate phase runs without a break from reset onward, during integration and in idle too. This keeps the sense node refreshed. Two sample strobes and a line marker tell a downstream converter when the reset level and the signal level of each pixel are stable. A one-cycle pulse marks the end of the frame. Every duration is a parameter expressed in system-clock ticks: the vertical pulse width, the horizontal setup, the pixel period and the reset width. The line count and the pixel count are parameters as well. There is no data stream and no handshake. All pins are plain levels and strobes.

Top module: `ccd_quad_sequencer`

## Requirements
- R1: After reset, and whenever the block is idle, v1, v2, h2, line_valid, frame_done, smp_rst and smp_sig are 0, and h1 and h1l are 1.
- R2: A start pulse seen while the block is idle begins integration in the next cycle. Integration lasts max(int_time,1) cycles, with v1 and v2 low, h1 and h1l high, and h2 low.
- R3: Each line transfer has three segments of VPULSE cycles each: v1 high alone, then v1 and v2 both high, then v2 high alone. A horizontal setup of HSETUP cycles follows, with both vertical phases low. h1 and h1l are high whenever v2 falls.
- R4: Each line takes 3*VPULSE + HSETUP + PIXELS*PIX_TICKS cycles. A frame's readout takes LINES line times, counted from the end of integration to the cycle before frame_done.
- R5: During pixel shifting, h1 is high for the first PIX_TICKS/2 cycles of each pixel period and low for the rest. h2 is always the complement of h1, h1l always equals h1, and h1 and h2 are never low together.
- R6: rg is high for the first RST_TICKS cycles of every pixel period. It keeps pulsing in idle and during integration, and no rg high pulse is shorter than RST_TICKS cycles.
- R7: smp_rst pulses at pixel phase RST_TICKS+1, one cycle after rg has fallen. smp_sig pulses at pixel phase PIX_TICKS/2+1, one cycle after h1l has fallen. Each strobe fires once per pixel, and only while line_valid is high.
- R8: line_valid is high for exactly PIXELS*PIX_TICKS consecutive cycles per line and is low outside pixel shifting.
- R9: frame_done is high for exactly one cycle, the cycle right after the last pixel of line LINES. The block is then idle.
- R10: A start pulse while a frame is in progress is ignored. The frame's length and its single frame_done are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all durations are counted in its ticks |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Frame start request, honoured only when idle |
| int_time | input | INT_W | Integration length in cycles, latched at start (0 acts as 1) |
| v1 | output | 1 | Vertical phase 1 |
| v2 | output | 1 | Vertical phase 2; a line enters the horizontal register on its fall |
| h1 | output | 1 | Horizontal phase 1 |
| h1l | output | 1 | Last horizontal gate; each fall moves one packet to the sense node |
| h2 | output | 1 | Horizontal phase 2, complement of h1 |
| rg | output | 1 | Sense-node reset gate |
| smp_rst | output | 1 | Strobe: sample the reset level |
| smp_sig | output | 1 | Strobe: sample the signal level |
| line_valid | output | 1 | High while the pixels of a line are being shifted |
| frame_done | output | 1 | One-cycle pulse after the final line |

## Verification
The bench builds the block with LINES=3, PIXELS=4, VPULSE=5, HSETUP=3, PIX_TICKS=10 and RST_TICKS=2. With these values a line takes 58 cycles and a whole frame is under 400 cycles. That brings the last-line exit, the wrap from one line back into the vertical transfer, and the half-period phase boundaries within a few hundred cycles. The short pixel period leaves one idle tick between each phase edge and its strobe. This lets the bench tell a strobe that is one cycle late from one that is on time. An integration value of 0 exercises the minimum-length corner, and a value of 200 spans many reset-gate periods during integration.

// File: rtl/ccd_seq_pkg.sv
`timescale 1ns/1ps
package ccd_seq_pkg;

  // Top-level sequence of one frame
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_INTEG = 3'd1,
    ST_VXFER = 3'd2,
    ST_HSET  = 3'd3,
    ST_PIXEL = 3'd4
  } seq_state_t;

  // Sub-steps of the vertical line transfer, in time order
  typedef enum logic [1:0] {
    VS_LEAD    = 2'd0,  // v1 alone
    VS_OVERLAP = 2'd1,  // v1 and v2
    VS_TRAIL   = 2'd2   // v2 alone, falls into horizontal setup
  } vseg_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_pix_phase.sv
`timescale 1ns/1ps
// Free-running pixel-period counter. It drives the reset gate continuously
// and restarts at phase 0 when a line's pixel shifting begins.
module ccd_pix_phase #(
  parameter int PIX_TICKS = 34,
  parameter int RST_TICKS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic wrap,
  output logic rg,
  output logic h1_phase,
  output logic rst_tap,
  output logic sig_tap
);
  localparam int HALF  = PIX_TICKS / 2;
  localparam int PH_W  = $clog2(PIX_TICKS) + 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(PIX_TICKS - 1);
  localparam logic [PH_W-1:0] PH_RST  = PH_W'(RST_TICKS);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF);
  localparam logic [PH_W-1:0] PH_RSMP = PH_W'(RST_TICKS + 1);
  localparam logic [PH_W-1:0] PH_SSMP = PH_W'(HALF + 1);

  logic [PH_W-1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              ph <= '0;
    else if (restart)        ph <= '0;
    else if (ph == PH_LAST)  ph <= '0;
    else                     ph <= ph + 1'b1;
  end

  assign wrap     = (ph == PH_LAST);
  assign rg       = (ph < PH_RST);
  assign h1_phase = (ph < PH_HALF);
  assign rst_tap  = (ph == PH_RSMP);
  assign sig_tap  = (ph == PH_SSMP);
endmodule

// File: rtl/ccd_line_ctrl.sv
`timescale 1ns/1ps
// Frame state machine: integration, per-line vertical transfer,
// horizontal setup and pixel shifting, with line and pixel counting.
module ccd_line_ctrl
  import ccd_seq_pkg::*;
#(
  parameter int LINES   = 1046,
  parameter int PIXELS  = 1050,
  parameter int VPULSE  = 3000,
  parameter int HSETUP  = 1000,
  parameter int INT_W   = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [INT_W-1:0] int_time,
  input  logic             pix_wrap,
  output seq_state_t       state,
  output vseg_t            vseg,
  output logic             enter_pix,
  output logic             frame_done
);
  localparam int SEG_MAX = max2(VPULSE, HSETUP);
  localparam int SW      = $clog2(SEG_MAX) + 1;
  localparam int PW      = $clog2(PIXELS) + 1;
  localparam int LW      = $clog2(LINES) + 1;
  localparam logic [SW-1:0] VP_LAST  = SW'(VPULSE - 1);
  localparam logic [SW-1:0] HS_LAST  = SW'(HSETUP - 1);
  localparam logic [PW-1:0] PIX_LAST = PW'(PIXELS - 1);
  localparam logic [LW-1:0] LIN_LAST = LW'(LINES - 1);

  logic [INT_W-1:0] icnt;
  logic [SW-1:0]    tcnt;
  logic [PW-1:0]    pcnt;
  logic [LW-1:0]    lcnt;

  assign enter_pix = (state == ST_HSET) && (tcnt == HS_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      vseg       <= VS_LEAD;
      icnt       <= '0;
      tcnt       <= '0;
      pcnt       <= '0;
      lcnt       <= '0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_INTEG;
            icnt  <= int_time;
          end
        end
        ST_INTEG: begin
          if (icnt <= INT_W'(1)) begin
            state <= ST_VXFER;
            vseg  <= VS_LEAD;
            tcnt  <= '0;
            lcnt  <= '0;
          end else begin
            icnt <= icnt - 1'b1;
          end
        end
        ST_VXFER: begin
          if (tcnt == VP_LAST) begin
            tcnt <= '0;
            if (vseg == VS_TRAIL) state <= ST_HSET;
            else                  vseg  <= vseg_t'(vseg + 2'd1);
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_HSET: begin
          if (tcnt == HS_LAST) begin
            state <= ST_PIXEL;
            tcnt  <= '0;
            pcnt  <= '0;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        ST_PIXEL: begin
          if (pix_wrap) begin
            if (pcnt == PIX_LAST) begin
              if (lcnt == LIN_LAST) begin
                state      <= ST_IDLE;
                frame_done <= 1'b1;
              end else begin
                lcnt  <= lcnt + 1'b1;
                state <= ST_VXFER;
                vseg  <= VS_LEAD;
              end
            end else begin
              pcnt <= pcnt + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_phase_drive.sv
`timescale 1ns/1ps
// Decodes the sequence position into clock phase levels and strobes.
module ccd_phase_drive
  import ccd_seq_pkg::*;
(
  input  seq_state_t state,
  input  vseg_t      vseg,
  input  logic       h1_phase,
  input  logic       rst_tap,
  input  logic       sig_tap,
  output logic       v1,
  output logic       v2,
  output logic       h1,
  output logic       h1l,
  output logic       h2,
  output logic       smp_rst,
  output logic       smp_sig,
  output logic       line_valid
);
  logic in_xfer;
  logic in_pix;

  assign in_xfer = (state == ST_VXFER);
  assign in_pix  = (state == ST_PIXEL);

  always_comb begin
    v1 = in_xfer && (vseg != VS_TRAIL);
    v2 = in_xfer && (vseg != VS_LEAD);
    // outside shifting the horizontal register parks with phase 1 high
    h1 = in_pix ? h1_phase : 1'b1;
    h2 = in_pix ? ~h1_phase : 1'b0;
    h1l = h1;
    line_valid = in_pix;
    smp_rst = in_pix && rst_tap;
    smp_sig = in_pix && sig_tap;
  end
endmodule

// File: rtl/ccd_quad_sequencer.sv
`timescale 1ns/1ps
module ccd_quad_sequencer
  import ccd_seq_pkg::*;
#(
  parameter int LINES     = 1046,
  parameter int PIXELS    = 1050,
  parameter int VPULSE    = 3000,
  parameter int HSETUP    = 1000,
  parameter int PIX_TICKS = 34,
  parameter int RST_TICKS = 2,
  parameter int INT_W     = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [INT_W-1:0] int_time,
  output logic             v1,
  output logic             v2,
  output logic             h1,
  output logic             h1l,
  output logic             h2,
  output logic             rg,
  output logic             smp_rst,
  output logic             smp_sig,
  output logic             line_valid,
  output logic             frame_done
);
  seq_state_t state;
  vseg_t      vseg;
  logic       enter_pix;
  logic       pix_wrap;
  logic       h1_phase;
  logic       rst_tap;
  logic       sig_tap;

  ccd_pix_phase #(
    .PIX_TICKS(PIX_TICKS),
    .RST_TICKS(RST_TICKS)
  ) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (enter_pix),
    .wrap     (pix_wrap),
    .rg       (rg),
    .h1_phase (h1_phase),
    .rst_tap  (rst_tap),
    .sig_tap  (sig_tap)
  );

  ccd_line_ctrl #(
    .LINES  (LINES),
    .PIXELS (PIXELS),
    .VPULSE (VPULSE),
    .HSETUP (HSETUP),
    .INT_W  (INT_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .int_time   (int_time),
    .pix_wrap   (pix_wrap),
    .state      (state),
    .vseg       (vseg),
    .enter_pix  (enter_pix),
    .frame_done (frame_done)
  );

  ccd_phase_drive u_drive (
    .state      (state),
    .vseg       (vseg),
    .h1_phase   (h1_phase),
    .rst_tap    (rst_tap),
    .sig_tap    (sig_tap),
    .v1         (v1),
    .v2         (v2),
    .h1         (h1),
    .h1l        (h1l),
    .h2         (h2),
    .smp_rst    (smp_rst),
    .smp_sig    (smp_sig),
    .line_valid (line_valid)
  );
endmodule

// File: rtl/ccd_seq_chk.sv
`timescale 1ns/1ps
module ccd_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic v1,
  input logic v2,
  input logic h1,
  input logic h1l,
  input logic h2,
  input logic rg,
  input logic smp_rst,
  input logic smp_sig,
  input logic line_valid,
  input logic frame_done
);
  // R5
  no_both_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!h1 && !h2));

  // R3
  v2_fall_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(v2) |-> (h1 && h1l));

  // R7
  sig_after_h1l_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_sig |-> (!h1l && !$past(h1l) && $past(h1l, 2) && line_valid));

  // R7
  rst_after_rg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_rst |-> (!rg && !$past(rg) && $past(rg, 2) && line_valid));

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R8
  valid_vquiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid |-> (!v1 && !v2));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (!line_valid && !v1 && !v2 && $past(line_valid)));
endmodule

bind ccd_quad_sequencer ccd_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .v1         (v1),
  .v2         (v2),
  .h1         (h1),
  .h1l        (h1l),
  .h2         (h2),
  .rg         (rg),
  .smp_rst    (smp_rst),
  .smp_sig    (smp_sig),
  .line_valid (line_valid),
  .frame_done (frame_done)
);

// File: tb/sim_ccd_quad_sequencer.sv
`timescale 1ns/1ps
module sim_ccd_quad_sequencer;
  localparam int LINES  = 3;
  localparam int PIXELS = 4;
  localparam int VP     = 5;
  localparam int HS     = 3;
  localparam int PIX    = 10;
  localparam int RSTW   = 2;
  localparam int INT_W  = 8;
  localparam int HALF   = PIX / 2;
  localparam int LT     = 3 * VP + HS + PIXELS * PIX;
  localparam int NVEC   = 4;
  // integration value applied, expected integration cycles
  localparam int TV_INT [NVEC] = '{0, 1, 7, 200};
  localparam int TV_EXP [NVEC] = '{1, 1, 7, 200};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [INT_W-1:0] int_time = '0;
  logic v1, v2, h1, h1l, h2, rg, smp_rst, smp_sig, line_valid, frame_done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ccd_quad_sequencer #(
    .LINES(LINES), .PIXELS(PIXELS), .VPULSE(VP), .HSETUP(HS),
    .PIX_TICKS(PIX), .RST_TICKS(RSTW), .INT_W(INT_W)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .int_time(int_time),
    .v1(v1), .v2(v2), .h1(h1), .h1l(h1l), .h2(h2), .rg(rg),
    .smp_rst(smp_rst), .smp_sig(smp_sig), .line_valid(line_valid),
    .frame_done(frame_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Runs one frame; optionally pokes start mid-frame (R10)
  task automatic run_frame(input int itime, input int exp_int, input bit poke);
    int n_int, tot, lv, ssig, srst, v2f, v1h, v2h, dn, rg_up, bad_ovl, bad_h1l;
    int bad_park, bad_lowrun, bad_rgrun, lowrun, rgrun;
    logic pv2, ph1, prg;
    n_int = 0; tot = 0; lv = 0; ssig = 0; srst = 0; v2f = 0; v1h = 0; v2h = 0;
    dn = 0; rg_up = 0; bad_ovl = 0; bad_h1l = 0; bad_park = 0; bad_lowrun = 0;
    bad_rgrun = 0; lowrun = 0; rgrun = RSTW;
    int_time = INT_W'(itime);
    start = 1'b1;
    step();
    start = 1'b0;
    pv2 = v2; ph1 = h1; prg = rg;
    while (!v1 && n_int < 1000) begin
      n_int++;
      if (rg && !prg) rg_up++;
      if (v2 || h2 || !h1 || !h1l) bad_park++;
      prg = rg;
      step();
    end
    tot = 0;
    while (!frame_done && tot < 5000) begin
      start = poke && (tot == 50);
      tot++;
      if (line_valid) lv++;
      if (smp_sig) ssig++;
      if (smp_rst) srst++;
      if (v1) v1h++;
      if (v2) v2h++;
      if (pv2 && !v2) begin v2f++; if (!h1 || !h1l) bad_park++; end
      if (!h1 && !h2) bad_ovl++;
      if (h1l != h1) bad_h1l++;
      if (!h1) lowrun++;
      if (h1 && !ph1) begin if (lowrun != HALF) bad_lowrun++; lowrun = 0; end
      if (rg) rgrun++;
      if (!rg && prg) begin if (rgrun < RSTW) bad_rgrun++; rgrun = 0; end
      pv2 = v2; ph1 = h1; prg = rg;
      step();
    end
    start = 1'b0;
    // count frame_done cycles over a quiet window after the frame
    for (int k = 0; k < 80; k++) begin
      if (frame_done) dn++;
      if (v1 || v2 || line_valid) bad_park++;
      step();
    end
    chk("R2 integration cycles", n_int, exp_int);
    chk("R4 readout cycles", tot, LINES * LT);
    chk("R8 line_valid cycles", lv, LINES * PIXELS * PIX);
    chk("R7 signal strobes", ssig, LINES * PIXELS);
    chk("R7 reset strobes", srst, LINES * PIXELS);
    chk("R3 v2 falls", v2f, LINES);
    chk("R3 v1 high cycles", v1h, 2 * VP * LINES);
    chk("R3 v2 high cycles", v2h, 2 * VP * LINES);
    chk("R9 frame_done pulses", dn, 1);
    chk("R5 h1/h2 both low", bad_ovl, 0);
    chk("R5 h1l equals h1", bad_h1l, 0);
    chk("R5 h1 low run length", bad_lowrun, 0);
    chk("R6 rg short pulses", bad_rgrun, 0);
    chk("R3 parked levels", bad_park, 0);
    if (exp_int >= 200) begin
      checks++;
      if (rg_up < exp_int / PIX - 1) begin
        fails++;
        $display("FAIL R6 rg pulses in integration: actual %0d expected >= %0d",
                 rg_up, exp_int / PIX - 1);
      end
    end
  endtask

  initial begin
    int rg_tog;
    logic prg;
    repeat (3) step();
    // R1: levels held in reset
    chk("R1 v1 in reset", v1, 0);
    chk("R1 h1 in reset", h1, 1);
    rst_n = 1'b1;
    step();
    step();
    chk("R1 v2 idle", v2, 0);
    chk("R1 h2 idle", h2, 0);
    chk("R1 h1l idle", h1l, 1);
    chk("R1 line_valid idle", line_valid, 0);
    chk("R1 frame_done idle", frame_done, 0);
    chk("R1 strobes idle", smp_rst | smp_sig, 0);
    // R6: reset gate keeps pulsing while idle
    rg_tog = 0;
    prg = rg;
    for (int k = 0; k < 40; k++) begin
      if (rg && !prg) rg_tog++;
      prg = rg;
      step();
    end
    checks++;
    if (rg_tog < 3) begin
      fails++;
      $display("FAIL R6 idle rg pulses: actual %0d expected >= 3", rg_tog);
    end
    // table of integration vectors
    for (int i = 0; i < NVEC; i++) run_frame(TV_INT[i], TV_EXP[i], 1'b0);
    // R10: start during a running frame is ignored
    run_frame(4, 4, 1'b1);
    // R9: block is idle again after frame_done
    chk("R9 idle after frame v1", v1, 0);
    chk("R9 idle after frame h1", h1, 1);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule